// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

This block watches a recovered receive bit stream, sampling one bit on each clock where the bit enable is high. It declares a digital loss of signal when a run of consecutive zeros reaches a limit. The limit is chosen by a mode input: a long limit for T1/DS1 lines and a short limit for E1/CEPT lines.

Once loss is declared, the block splits the arriving bits into fixed, back-to-back windows. The first window begins with the first bit after the flag rises. A window passes if it carries enough ones and contains no zero run longer than a quiet limit. The zero-run count is not restarted at a window edge, so a run that crosses from one window into the next is measured as one run. The flag drops at the close of the second passing window in a row.

A second output merges the digital flag with an analog loss input from the line front end. Line decoding, clock recovery and clock switchover are handled elsewhere.

Top module: `dlos_detector`

## Requirements
- R1: With `mode_short` = 0, `loss_flag` rises in the cycle after the bit that completes LONG_LIMIT (default 128) consecutive zeros. One bit fewer leaves it low.
- R2: With `mode_short` = 1, the same happens at SHORT_LIMIT (default 32) consecutive zeros.
- R3: A bit is taken only on a clock where `bit_en` is high. On other clocks `bit_in` has no effect, and `loss_flag` does not change.
- R4: While `loss_flag` is high, the received bits are grouped into windows of WIN_LEN (default 32) bits. The first window starts with the first bit after the flag rose. A window passes only if it holds at least MIN_ONES (default 4) ones and no zero run longer than MAX_QUIET (default 15).
- R5: The zero-run count continues across window edges, and it includes the run that raised the flag. The counter stops at its maximum value and never wraps.
- R6: `loss_flag` falls in the cycle after the last bit of the GOOD_WINDOWS-th (default 2) consecutive passing window. A failing window sets the count of passing windows back to zero.
- R7: `loss_any` is high exactly when `loss_flag` or `analog_loss` is high.
- R8: Reset clears `loss_flag` and all run and window counts.
- R9: A change on `mode_short` clears the zero-run and window counts and leaves `loss_flag` unchanged. The new limit applies from the next bit that is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` on this clock |
| bit_in | input | 1 | Received data bit |
| mode_short | input | 1 | 0: long zero limit (T1/DS1); 1: short zero limit (E1/CEPT) |
| analog_loss | input | 1 | Analog loss indication from the line front end |
| loss_flag | output | 1 | Digital loss of signal |
| loss_any | output | 1 | OR of digital and analog loss |

## Verification
The bench builds the block with LONG_LIMIT 20, SHORT_LIMIT 8, WIN_LEN 8, MIN_ONES 2, MAX_QUIET 3 and GOOD_WINDOWS 2. At this size every run length around both thresholds can be swept. All 256 patterns of a first recovery window can be enumerated, each followed by passing windows. This exercises the ones minimum, the quiet limit, runs that cross a window edge, and the count restarting after a failed window. A long pseudo-random stream with changing ones density is then compared bit by bit against an arithmetic model. That stream includes mode changes and idle clocks.

// File: rtl/dlos_pkg.sv
package dlos_pkg;

    typedef enum logic {
        MODE_LONG  = 1'b0,
        MODE_SHORT = 1'b1
    } line_mode_e;

    localparam int unsigned DEF_LONG_LIMIT   = 128;
    localparam int unsigned DEF_SHORT_LIMIT  = 32;
    localparam int unsigned DEF_WIN_LEN      = 32;
    localparam int unsigned DEF_MIN_ONES     = 4;
    localparam int unsigned DEF_MAX_QUIET    = 15;
    localparam int unsigned DEF_GOOD_WINDOWS = 2;

endpackage

// File: rtl/dlos_run_counter.sv
// Saturating count of consecutive zeros on the qualified bit stream.
module dlos_run_counter #(
    parameter int unsigned RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             clear,
    output logic [RUN_W-1:0] run_next_o
);

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } run_state_t;

    run_state_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (clear) begin
            run_d.run = '0;
        end else if (bit_en) begin
            if (bit_in) begin
                run_d.run = '0;
            end else if (run_q.run != {RUN_W{1'b1}}) begin
                run_d.run = run_q.run + RUN_W'(1);
            end
        end
    end

    assign run_next_o = run_d.run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

endmodule

// File: rtl/dlos_window_judge.sv
// Grades fixed recovery windows while loss is declared and signals release.
module dlos_window_judge #(
    parameter int unsigned WIN_LEN      = 32,
    parameter int unsigned MIN_ONES     = 4,
    parameter int unsigned MAX_QUIET    = 15,
    parameter int unsigned GOOD_WINDOWS = 2,
    parameter int unsigned RUN_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic [RUN_W-1:0] run_next,
    output logic             release_o
);

    localparam int unsigned POS_W  = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam int unsigned ONES_W = $clog2(WIN_LEN + 1);
    localparam int unsigned GOOD_W = $clog2(GOOD_WINDOWS + 1);

    localparam logic [POS_W-1:0]  LAST_POS   = POS_W'(WIN_LEN - 1);
    localparam logic [ONES_W-1:0] ONES_NEED  = ONES_W'(MIN_ONES);
    localparam logic [RUN_W-1:0]  QUIET_MAX  = RUN_W'(MAX_QUIET);
    localparam logic [GOOD_W-1:0] GOOD_FINAL = GOOD_W'(GOOD_WINDOWS - 1);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [ONES_W-1:0] ones;
        logic              bad;
        logic [GOOD_W-1:0] good;
    } win_state_t;

    win_state_t win_d, win_q;
    logic [ONES_W-1:0] ones_sum;
    logic              bad_sum;
    logic              window_ok;

    always_comb begin
        win_d     = win_q;
        release_o = 1'b0;
        ones_sum  = win_q.ones + ONES_W'(bit_in);
        bad_sum   = win_q.bad | (!bit_in && (run_next > QUIET_MAX));
        window_ok = (ones_sum >= ONES_NEED) && !bad_sum;
        if (restart || !active) begin
            win_d = '0;
        end else if (bit_en) begin
            if (win_q.pos == LAST_POS) begin
                win_d.pos  = '0;
                win_d.ones = '0;
                win_d.bad  = 1'b0;
                if (!window_ok) begin
                    win_d.good = '0;
                end else if (win_q.good == GOOD_FINAL) begin
                    win_d.good = '0;
                    release_o  = 1'b1;
                end else begin
                    win_d.good = win_q.good + GOOD_W'(1);
                end
            end else begin
                win_d.pos  = win_q.pos + POS_W'(1);
                win_d.ones = ones_sum;
                win_d.bad  = bad_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

endmodule

// File: rtl/dlos_detector.sv
module dlos_detector
    import dlos_pkg::*;
#(
    parameter int unsigned LONG_LIMIT   = DEF_LONG_LIMIT,
    parameter int unsigned SHORT_LIMIT  = DEF_SHORT_LIMIT,
    parameter int unsigned WIN_LEN      = DEF_WIN_LEN,
    parameter int unsigned MIN_ONES     = DEF_MIN_ONES,
    parameter int unsigned MAX_QUIET    = DEF_MAX_QUIET,
    parameter int unsigned GOOD_WINDOWS = DEF_GOOD_WINDOWS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    input  logic mode_short,
    input  logic analog_loss,
    output logic loss_flag,
    output logic loss_any
);

    localparam int unsigned TOP_LIMIT = (LONG_LIMIT > SHORT_LIMIT) ? LONG_LIMIT : SHORT_LIMIT;
    localparam int unsigned RUN_W     = $clog2(TOP_LIMIT + 1);
    localparam logic [RUN_W-1:0] LONG_CNT  = RUN_W'(LONG_LIMIT);
    localparam logic [RUN_W-1:0] SHORT_CNT = RUN_W'(SHORT_LIMIT);

    typedef struct packed {
        logic       flag;
        line_mode_e mode;
    } top_state_t;

    top_state_t       top_d, top_q;
    line_mode_e       mode_in;
    logic             mode_chg;
    logic [RUN_W-1:0] run_next;
    logic [RUN_W-1:0] limit;
    logic             trip;
    logic             win_release;

    assign mode_in  = line_mode_e'(mode_short);
    assign mode_chg = (mode_in != top_q.mode);
    assign limit    = (top_q.mode == MODE_SHORT) ? SHORT_CNT : LONG_CNT;

    dlos_run_counter #(
        .RUN_W (RUN_W)
    ) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .bit_in     (bit_in),
        .clear      (mode_chg),
        .run_next_o (run_next)
    );

    dlos_window_judge #(
        .WIN_LEN      (WIN_LEN),
        .MIN_ONES     (MIN_ONES),
        .MAX_QUIET    (MAX_QUIET),
        .GOOD_WINDOWS (GOOD_WINDOWS),
        .RUN_W        (RUN_W)
    ) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (top_q.flag),
        .restart   (mode_chg),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .run_next  (run_next),
        .release_o (win_release)
    );

    always_comb begin
        top_d      = top_q;
        top_d.mode = mode_in;
        trip = !top_q.flag && bit_en && !bit_in && !mode_chg && (run_next >= limit);
        if (trip)             top_d.flag = 1'b1;
        else if (win_release) top_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.flag <= 1'b0;
            top_q.mode <= MODE_LONG;
        end else begin
            top_q <= top_d;
        end
    end

    assign loss_flag = top_q.flag;
    assign loss_any  = top_q.flag | analog_loss;

endmodule

// File: rtl/dlos_detector_checker.sv
module dlos_detector_checker #(
    parameter int unsigned WIN_LEN      = 32,
    parameter int unsigned GOOD_WINDOWS = 2
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic bit_in,
    input logic analog_loss,
    input logic loss_flag,
    input logic loss_any
);

    localparam int unsigned HOLD_MIN = WIN_LEN * GOOD_WINDOWS;
    localparam int unsigned HOLD_W   = $clog2(HOLD_MIN + 1);

    logic [HOLD_W-1:0] held_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_bits <= '0;
        end else if (!loss_flag) begin
            held_bits <= '0;
        end else if (bit_en && held_bits != {HOLD_W{1'b1}}) begin
            held_bits <= held_bits + HOLD_W'(1);
        end
    end

    assert_rise_on_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_flag) |-> ($past(bit_en) && !$past(bit_in)));

    assert_hold_without_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(loss_flag));

    assert_fall_on_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loss_flag) |-> $past(bit_en));

    assert_min_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loss_flag) |-> (held_bits >= HOLD_W'(HOLD_MIN)));

    assert_any_analog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        analog_loss |-> loss_any);

    assert_any_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loss_flag |-> loss_any);

    assert_any_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!loss_flag && !analog_loss) |-> !loss_any);

endmodule

bind dlos_detector dlos_detector_checker #(
    .WIN_LEN      (WIN_LEN),
    .GOOD_WINDOWS (GOOD_WINDOWS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .bit_in      (bit_in),
    .analog_loss (analog_loss),
    .loss_flag   (loss_flag),
    .loss_any    (loss_any)
);

// File: tb/dlos_detector_test.sv
`timescale 1ns/1ps
module dlos_detector_test;

    localparam int LIM_L = 20;
    localparam int LIM_S = 8;
    localparam int WLEN  = 8;
    localparam int ONES  = 2;
    localparam int QUIET = 3;
    localparam int GOODN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic mode_short = 1'b0;
    logic analog_loss = 1'b0;
    logic loss_flag, loss_any;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // arithmetic reference state
    int m_run = 0, m_flag = 0, m_pos = 0, m_ones = 0, m_bad = 0, m_good = 0;

    always #4 clk = ~clk;

    dlos_detector #(
        .LONG_LIMIT(LIM_L), .SHORT_LIMIT(LIM_S), .WIN_LEN(WLEN),
        .MIN_ONES(ONES), .MAX_QUIET(QUIET), .GOOD_WINDOWS(GOODN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .mode_short(mode_short), .analog_loss(analog_loss),
        .loss_flag(loss_flag), .loss_any(loss_any)
    );

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            summary();
        end
    end

    task automatic clear_window();
        m_pos = 0; m_ones = 0; m_bad = 0; m_good = 0;
    endtask

    task automatic model_bit(input int b);
        int lim;
        lim = mode_short ? LIM_S : LIM_L;
        m_run = b ? 0 : m_run + 1;
        if (m_flag == 0) begin
            if (b == 0 && m_run >= lim) begin
                m_flag = 1;
                clear_window();
            end
        end else begin
            m_pos++;
            m_ones += b;
            if (b == 0 && m_run > QUIET) m_bad = 1;
            if (m_pos == WLEN) begin
                if (m_ones >= ONES && m_bad == 0) m_good++;
                else m_good = 0;
                m_pos = 0; m_ones = 0; m_bad = 0;
                if (m_good == GOODN) begin
                    m_flag = 0;
                    m_good = 0;
                end
            end
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (loss_flag !== m_flag[0]) begin
            fails++;
            $display("FAIL %s: loss_flag actual %b expected %0d", tag, loss_flag, m_flag);
        end
        checks++;
        if (loss_any !== (m_flag[0] | analog_loss)) begin
            fails++;
            $display("FAIL R7 (%s): loss_any actual %b expected %b", tag, loss_any,
                     m_flag[0] | analog_loss);
        end
    endtask

    // one bit, then an idle clock with bit_in inverted (must be ignored: R3)
    task automatic push(input int b, input string tag);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b[0];
        model_bit(b);
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = ~b[0];
        check(tag);
    endtask

    task automatic push_byte(input int p, input string tag);
        for (int i = 0; i < WLEN; i++) push((p >> i) & 1, tag);
    endtask

    task automatic do_reset(input int mode);
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        mode_short = mode[0];
        m_run = 0; m_flag = 0;
        clear_window();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8");
    endtask

    task automatic set_mode(input int mode);
        @(negedge clk);
        if (mode_short != mode[0]) begin
            m_run = 0;
            clear_window();
        end
        mode_short = mode[0];
        @(negedge clk);
        check("R9");
    endtask

    initial begin
        logic [15:0] lfsr;
        // reset state
        do_reset(0);

        // R1: long-limit threshold sweep
        for (int n = 0; n <= LIM_L + 1; n++) begin
            do_reset(0);
            push(1, "R1");
            for (int k = 0; k < n; k++) push(0, "R1");
        end

        // R2: short-limit threshold sweep
        for (int n = 0; n <= LIM_S + 1; n++) begin
            do_reset(1);
            push(1, "R2");
            for (int k = 0; k < n; k++) push(0, "R2");
        end

        // R7: analog input with flag low and high
        do_reset(1);
        for (int a = 0; a < 2; a++) begin
            @(negedge clk); analog_loss = a[0]; @(negedge clk); check("R7");
        end
        for (int k = 0; k < LIM_S; k++) push(0, "R2");
        for (int a = 0; a < 2; a++) begin
            @(negedge clk); analog_loss = a[0]; @(negedge clk); check("R7");
        end
        analog_loss = 1'b0;

        // R3: long idle stretch with toggling data while flag is set
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); bit_in = k[0]; @(negedge clk); check("R3");
        end

        // R4/R5/R6: every first-window pattern, then passing windows
        for (int p = 0; p < 256; p++) begin
            do_reset(1);
            for (int k = 0; k < LIM_S; k++) push(0, "R4");
            push_byte(p, "R4");
            push_byte(8'h55, "R5");
            push_byte(8'h55, "R6");
            push_byte(8'h55, "R6");
        end

        // R6: pass, fail, pass, pass
        do_reset(1);
        for (int k = 0; k < LIM_S; k++) push(0, "R6");
        push_byte(8'h11, "R6");
        push_byte(8'h01, "R6");
        push_byte(8'h11, "R6");
        push_byte(8'h11, "R6");

        // R9: mode change mid-run clears the run; flag unaffected by changes
        do_reset(0);
        for (int k = 0; k < LIM_L - 2; k++) push(0, "R9");
        set_mode(1);
        for (int k = 0; k < LIM_S; k++) push(0, "R9");
        set_mode(0);
        push_byte(8'h55, "R9");
        set_mode(1);
        push_byte(8'h55, "R9");
        push_byte(8'h55, "R9");

        // R5: pseudo-random stream with varying density and mode changes
        lfsr = 16'hACE1;
        do_reset(0);
        for (int i = 0; i < 6000; i++) begin
            int dens;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dens = (i / 500) % 4;
            if (i % 1500 == 700) set_mode(~mode_short);
            push(((lfsr[3:0] & 4'((1 << dens) - 1)) == 0 && lfsr[7:4] != 0) ? 1 : 0, "R5");
        end

        summary();
    end

endmodule